// File: doc/BRIEF.md
# Parallel-Load Shift Register with Gated Shift Clock

This block is a register of eight stages (width set by a parameter) that either copies a parallel word or shifts serial data toward its last stage. It provides the last-stage value and its complement as outputs. The whole block runs on one system clock. The external shift-clock pin, the active-low enable pin, the active-low load pin, the serial input and the parallel inputs each pass through a two-flop synchroniser. Edges of the shift clock are found inside the block by comparing the synchronised clock with its value one cycle earlier.

The shift clock seen by the register is the OR of the clock pin and the enable pin. The two pins are interchangeable, and a rising edge on either one can cause a shift. While load is low, the register follows the parallel word and ignores the clock. Feeding the serial output of one instance into the serial input of the next builds a longer converter.

A change on any pin reaches the outputs on the third rising edge of the system clock after it. Reset is synchronous and active high. It must be held for at least three cycles so that the synchronisers settle on the current pin levels.

Top module: `pls_shifter`

## Requirements
- R1: While `rst` is high, all stages clear to zero. After a reset of three or more cycles, `ser_out` is 0 and `ser_out_n` is 1.
- R2: While `load_n` is low, the stages continuously take the value of `par_in`, whatever the clock and enable pins do. `ser_out` then shows `par_in[WIDTH-1]`.
- R3: While `load_n` is high, each rising edge of the effective clock (`sclk_pin` OR `sen_n_pin`) moves stage i into stage i+1 and puts `ser_in` into stage 0. `ser_out` shows stage WIDTH-1.
- R4: While `sen_n_pin` stays high, edges on `sclk_pin` cause no shift.
- R5: When `sen_n_pin` goes from low to high while `sclk_pin` is low, exactly one shift occurs. The two pins act the same way.
- R6: When `load_n` goes from low to high while the effective clock is already high, no shift occurs at that release.
- R7: `ser_out_n` is always the complement of `ser_out`.
- R8: When the `ser_out` of one instance drives the `ser_in` of a second, and both share the clock, enable and load pins, the pair shifts as one 16-stage register in the correct order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | Asynchronous shift-clock pin |
| sen_n_pin | input | 1 | Asynchronous active-low shift enable, ORed with `sclk_pin` |
| load_n | input | 1 | Asynchronous active-low parallel load, level sensitive |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel word |
| ser_out | output | 1 | Last-stage value |
| ser_out_n | output | 1 | Complement of the last-stage value |

## Verification
Three cases are the hardest to reach from the ports: a shift caused only by enable, a load release while the effective clock is high, and a chained pair whose second stage must capture the first one's output from before the shift. The stimulus changes one pin at a time and leaves four system cycles between changes, so every transition passes through the synchronisers. It parks the clock pin low before raising enable, and it releases load with the clock pin high. Two instances are chained, and a 16-bit model is compared with both serial outputs after every pin change.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned DEF_WIDTH = 8;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic sclk;
    logic sen_n;
    logic load_n;
    logic ser;
  } pls_ctl_t;
endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [DEPTH];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) chain[i] <= chain[i-1];
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/pls_clk_edge.sv
module pls_clk_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic sen_n_s,
  output logic eff,
  output logic eff_q,
  output logic rise
);
  assign eff = sclk_s | sen_n_s;

  // Tracks during reset so no false edge appears on reset release.
  always_ff @(posedge clk) eff_q <= eff;

  assign rise = eff & ~eff_q;

  // R4: enable held high gates the clock pin completely
  a_r4_gated: assert property (@(posedge clk) disable iff (rst)
    (sen_n_s && $past(sen_n_s)) |-> !rise);

  // R5: enable rising while clock is low produces an edge
  a_r5_enable_edge: assert property (@(posedge clk) disable iff (rst)
    (!sclk_s && !$past(sclk_s) && sen_n_s && !$past(sen_n_s)) |-> rise);
endmodule

// File: rtl/pls_stages.sv
module pls_stages #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n_s,
  input  logic         ser_s,
  input  logic [W-1:0] par_s,
  input  logic         rise,
  output logic [W-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst)            stages <= '0;
    else if (!load_n_s) stages <= par_s;
    else if (rise)      stages <= {stages[W-2:0], ser_s};
  end

  // R1: reset clears every stage
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (stages == '0));

  // R2: load low copies the parallel word
  a_r2_load_track: assert property (@(posedge clk) disable iff (rst)
    (!load_n_s) |=> (stages == $past(par_s)));

  // R3: a detected edge shifts one place toward the last stage
  a_r3_shift: assert property (@(posedge clk) disable iff (rst)
    (load_n_s && rise) |=> (stages == {$past(stages[W-2:0]), $past(ser_s)}));

  // R3: without an edge the contents hold
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n_s && !rise) |=> $stable(stages));
endmodule

// File: rtl/pls_shifter.sv
module pls_shifter
  import pls_pkg::*;
#(
  parameter int unsigned WIDTH      = DEF_WIDTH,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_pin,
  input  logic             sen_n_pin,
  input  logic             load_n,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int unsigned CTL_W = $bits(pls_ctl_t);

  pls_ctl_t         ctl_raw, ctl_s;
  logic [WIDTH-1:0] par_s;
  logic             eff, eff_q, rise;
  logic [WIDTH-1:0] stages;

  assign ctl_raw = '{sclk: sclk_pin, sen_n: sen_n_pin, load_n: load_n, ser: ser_in};

  pls_sync #(.W(CTL_W), .DEPTH(SYNC_DEPTH)) u_ctl_sync (
    .clk(clk), .d(ctl_raw), .q(ctl_s)
  );

  pls_sync #(.W(WIDTH), .DEPTH(SYNC_DEPTH)) u_par_sync (
    .clk(clk), .d(par_in), .q(par_s)
  );

  pls_clk_edge u_edge (
    .clk(clk), .rst(rst), .sclk_s(ctl_s.sclk), .sen_n_s(ctl_s.sen_n),
    .eff(eff), .eff_q(eff_q), .rise(rise)
  );

  pls_stages #(.W(WIDTH)) u_stages (
    .clk(clk), .rst(rst), .load_n_s(ctl_s.load_n), .ser_s(ctl_s.ser),
    .par_s(par_s), .rise(rise), .stages(stages)
  );

  assign ser_out   = stages[WIDTH-1];
  assign ser_out_n = ~stages[WIDTH-1];

  // R6: releasing load while the effective clock is high does not shift
  a_r6_release_no_shift: assert property (@(posedge clk) disable iff (rst)
    (ctl_s.load_n && !$past(ctl_s.load_n) && $past(eff)) |=> $stable(stages));

  // R7: the two serial outputs differ (checked against the registered stage)
  a_r7_complement: assert property (@(posedge clk) disable iff (rst)
    ser_out_n != stages[WIDTH-1]);
endmodule

// File: tb/pls_shifter_tb_top.sv
module pls_shifter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_pin = 1'b0, sen_n_pin = 1'b0, load_n = 1'b1, ser_in = 1'b0;
  logic [7:0] par_a = 8'h00, par_b = 8'h00;
  logic out_a, out_an, out_b, out_bn;

  int checks = 0, fails = 0;
  logic [7:0] m_a = 8'h00, m_b = 8'h00;
  logic eff_prev = 1'b0;
  logic [1:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  pls_shifter dut_i (
    .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .sen_n_pin(sen_n_pin),
    .load_n(load_n), .ser_in(ser_in), .par_in(par_a),
    .ser_out(out_a), .ser_out_n(out_an)
  );

  pls_shifter dut2_i (
    .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .sen_n_pin(sen_n_pin),
    .load_n(load_n), .ser_in(out_a), .par_in(par_b),
    .ser_out(out_b), .ser_out_n(out_bn)
  );

  // Driver: one pin change, model update, then push the expected outputs.
  task automatic drive(input logic ck, input logic en_n, input logic ld_n,
                       input logic s, input logic [7:0] pa, input logic [7:0] pb,
                       input string tag);
    logic eff_now;
    @(negedge clk);
    sclk_pin = ck; sen_n_pin = en_n; load_n = ld_n; ser_in = s;
    par_a = pa; par_b = pb;
    eff_now = ck | en_n;
    if (!ld_n) begin
      m_a = pa; m_b = pb;
    end else if (eff_now && !eff_prev) begin
      m_b = {m_b[6:0], m_a[7]};
      m_a = {m_a[6:0], s};
    end
    eff_prev = eff_now;
    repeat (4) @(posedge clk);
    exp_q.push_back({m_b[7], m_a[7]});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare at the falling edge after each push.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (out_a !== e[0] || out_b !== e[1]) begin
          fails++;
          $display("FAIL %s: ser_out a=%b b=%b expected a=%b b=%b", t, out_a, out_b, e[0], e[1]);
        end
        checks++;
        if (out_an !== ~e[0] || out_bn !== ~e[1]) begin
          fails++;
          $display("FAIL R7 (%s): ser_out_n a=%b b=%b expected a=%b b=%b",
                   t, out_an, out_bn, ~e[0], ~e[1]);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: cycles=%0d expected < %0d", cyc, 20000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    drive(0, 0, 1, 0, 8'h00, 8'h00, "R1 reset state");
    // R2: load, track changes, clock ignored
    drive(0, 0, 0, 0, 8'hA5, 8'h3C, "R2 load");
    drive(0, 0, 0, 0, 8'h5A, 8'hC3, "R2 track");
    drive(1, 0, 0, 1, 8'h5A, 8'hC3, "R2 clock ignored");
    drive(0, 0, 0, 1, 8'hB1, 8'h96, "R2 reload");
    drive(0, 0, 1, 0, 8'hB1, 8'h96, "R3 release low clock");
    // R3/R8: 16 shifts through the chain with a mixed pattern
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = (i % 3 == 0) ^ i[0];
      drive(1, 0, 1, b, 8'hB1, 8'h96, "R3/R8 shift rise");
      drive(0, 0, 1, b, 8'hB1, 8'h96, "R3/R8 shift fall");
    end
    // R5: enable rising with clock low shifts once
    drive(0, 1, 1, 1, 8'h00, 8'h00, "R5 enable edge");
    // R4: clock pulses blocked by enable high
    for (int i = 0; i < 3; i++) begin
      drive(1, 1, 1, 0, 8'h00, 8'h00, "R4 gated rise");
      drive(0, 1, 1, 0, 8'h00, 8'h00, "R4 gated fall");
    end
    drive(0, 0, 1, 1, 8'h00, 8'h00, "R5 enable low");
    drive(0, 1, 1, 1, 8'h00, 8'h00, "R5 enable edge again");
    drive(0, 0, 1, 0, 8'h00, 8'h00, "R5 enable low");
    // R6: release load while clock high, then later edge shifts
    drive(1, 0, 1, 0, 8'h00, 8'h00, "R3 clock up");
    drive(1, 0, 0, 0, 8'h7E, 8'h81, "R6 load with clock high");
    drive(1, 0, 1, 1, 8'h7E, 8'h81, "R6 release no shift");
    drive(0, 0, 1, 1, 8'h7E, 8'h81, "R6 clock down");
    drive(1, 0, 1, 1, 8'h7E, 8'h81, "R6 next edge shifts");
    drive(0, 0, 1, 0, 8'h7E, 8'h81, "R8 fall");
    // R1: reset in mid-operation
    @(negedge clk) rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    m_a = 8'h00; m_b = 8'h00;
    drive(0, 0, 1, 0, 8'h7E, 8'h81, "R1 reset clears");
    repeat (3) @(posedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule